// File: doc/BRIEF.md
# Guard and Dead-Time Inserter for a Ternary H-Bridge

This block sits between a ternary PWM modulator and a full H-bridge. It turns each PWM word into four gate enables: a high-side and a low-side enable for each of the two bridge legs. Each word is a positive, negative or zero drive request with a pulse width in clock ticks. Leg A carries positive pulses and leg B carries negative ones. A leg with no pulse keeps its low-side switch on, so a zero word holds both low sides on and the load sees no switching.

Each pulse is placed inside its word with a guard interval before it and after it. Short pulses therefore never touch the word edges. A pulse shorter than two guards is either stretched to two guards or dropped, as chosen at build time. Each leg runs its own state machine, with states LEG_LOW, LEG_DEAD and LEG_HIGH. Every change of side passes through LEG_DEAD, where both switches are off for a fixed number of ticks. The transitions are: LEG_LOW to LEG_DEAD when a pulse is wanted; LEG_HIGH to LEG_DEAD when the pulse ends; LEG_DEAD to LEG_HIGH or LEG_LOW, whichever side is wanted when the dead count expires. Reset enters LEG_DEAD.

The guard length is adapted. A 1-bit load-current sign is synchronized and then read at every word boundary. It is compared with the polarity of the word that just ended. A mismatch lengthens the guard by one tick. A run of matches shortens it by one tick. The guard stays between a lower and an upper bound. With the default 10 ns tick, the guard starts at 30 ns and moves in 10 ns steps.

Top module: `hbridge_guard_deadtime`

## Requirements
- R1: While reset is low, all four enables are 0. After release, both low-side enables turn on after the DEAD_TICKS-th rising clock edge, and both high-side enables stay off.
- R2: In every cycle, the high-side and low-side enables of the same leg are never both 1.
- R3: Whenever a leg changes from one side to the other, both of its enables are 0 for exactly DEAD_TICKS cycles before the incoming side turns on.
- R4: A word is taken in the cycle `word_go` is 1. `cmd_pos`=1 with `cmd_neg`=0 means positive, driven on leg A. `cmd_neg`=1 with `cmd_pos`=0 means negative, driven on leg B. With guard G and effective width W, the driven leg's low side turns off G+1 cycles after the `word_go` cycle. Its high side turns on G+1+DEAD_TICKS cycles after that cycle and stays on for W−DEAD_TICKS cycles. The other leg's low side stays on.
- R5: The effective width never exceeds WORD_TICKS−2G. Larger requested widths are clamped to that value.
- R6: A nonzero requested width below 2G becomes exactly 2G when DROP_SHORT=0. When DROP_SHORT=1, the word produces no pulse and both low sides stay on.
- R7: `isense_sign` passes through two flip-flops. It is read in the `word_go` cycle and compared with the previous word's polarity, where 1 is expected after a positive word and 0 after a negative word. A mismatch raises the guard by one tick, up to GUARD_MAX, and clears the match run.
- R8: AGREE_RUNS consecutive matching checks lower the guard by one tick, down to GUARD_MIN, and restart the run.
- R9: A word with no drive (zero width, both requests or neither, or dropped) produces no pulse. The boundary that follows it makes no check, so the guard and the match run keep their values.
- R10: The guard changes only in a `word_go` cycle. The updated value already applies to the word taken in that same cycle.
- R11: The two high-side enables are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_go | input | 1 | Take a new PWM word this cycle |
| cmd_pos | input | 1 | Positive drive request |
| cmd_neg | input | 1 | Negative drive request |
| cmd_width | input | $clog2(WORD_TICKS+1) | Requested pulse width in ticks |
| isense_sign | input | 1 | Asynchronous load-current sign, 1 = positive |
| a_hi_en | output | 1 | Leg A high-side enable |
| a_lo_en | output | 1 | Leg A low-side enable |
| b_hi_en | output | 1 | Leg B high-side enable |
| b_lo_en | output | 1 | Leg B low-side enable |

## Verification
The guard update and the short-pulse rule fall in the same `word_go` cycle. The width test must then use the guard value being written in that cycle, not the one being replaced. The bench provokes this with a word whose width equals exactly twice the current guard, sent together with a current sign that contradicts the previous word. That raises the guard, so the same word becomes short and must be stretched to twice the new guard. The bench judges the result from where the high side turns on and how long it stays on, both predicted from the raised guard.

// File: rtl/gdt_pkg.sv
package gdt_pkg;

    typedef enum logic [1:0] {
        LEG_LOW  = 2'd0,
        LEG_DEAD = 2'd1,
        LEG_HIGH = 2'd2
    } leg_state_e;

    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_POS  = 2'd1,
        POL_NEG  = 2'd2
    } pol_e;

    localparam int unsigned LEGS = 2;

endpackage

// File: rtl/gdt_sync.sv
module gdt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], d};
        end
    end

    assign q = shift_q[STAGES-1];

endmodule

// File: rtl/gdt_guard_adapt.sv
module gdt_guard_adapt
    import gdt_pkg::*;
#(
    parameter int unsigned GW         = 3,
    parameter int unsigned GUARD_INIT = 3,
    parameter int unsigned GUARD_MIN  = 1,
    parameter int unsigned GUARD_MAX  = 6,
    parameter int unsigned AGREE_RUNS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  pol_e          last_pol,
    input  logic          sign_now,
    output logic [GW-1:0] guard_q,
    output logic [GW-1:0] guard_nxt
);

    localparam int unsigned RW = $clog2(AGREE_RUNS + 1);

    logic [RW-1:0] run_q;
    logic [RW-1:0] run_nxt;
    logic          expect_pos;

    // Compare the sampled sign with the polarity of the word just ended
    always_comb begin
        guard_nxt  = guard_q;
        run_nxt    = run_q;
        expect_pos = (last_pol == POL_POS);
        if (upd && (last_pol != POL_NONE)) begin
            if (sign_now != expect_pos) begin
                run_nxt = '0;
                if (guard_q < GW'(GUARD_MAX)) begin
                    guard_nxt = guard_q + 1'b1;
                end
            end else if (run_q == RW'(AGREE_RUNS - 1)) begin
                run_nxt = '0;
                if (guard_q > GW'(GUARD_MIN)) begin
                    guard_nxt = guard_q - 1'b1;
                end
            end else begin
                run_nxt = run_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            guard_q <= GW'(GUARD_INIT);
            run_q   <= '0;
        end else begin
            guard_q <= guard_nxt;
            run_q   <= run_nxt;
        end
    end

endmodule

// File: rtl/gdt_word_timer.sv
module gdt_word_timer
    import gdt_pkg::*;
#(
    parameter int unsigned WORD_TICKS = 64,
    parameter int unsigned GW         = 3,
    parameter int unsigned TW         = 7,
    parameter bit          DROP_SHORT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_go,
    input  logic          cmd_pos,
    input  logic          cmd_neg,
    input  logic [TW-1:0] cmd_width,
    input  logic [GW-1:0] guard_nxt,
    output pol_e          pol_q,
    output logic          drive_pos,
    output logic          drive_neg
);

    logic [TW:0]   two_g;
    logic [TW:0]   room;
    logic [TW:0]   w_shaped;
    logic [TW:0]   w_eff;
    logic [TW:0]   end_t;
    pol_e          cmd_pol;
    logic [TW-1:0] tick_q;
    logic [TW-1:0] width_q;
    logic [GW-1:0] guard_w;
    logic          active;

    // Shape the requested width with the guard being written this cycle
    always_comb begin
        two_g = (TW+1)'(guard_nxt) << 1;
        room  = (TW+1)'(WORD_TICKS) - two_g;
        if (cmd_pos && !cmd_neg) begin
            cmd_pol = POL_POS;
        end else if (cmd_neg && !cmd_pos) begin
            cmd_pol = POL_NEG;
        end else begin
            cmd_pol = POL_NONE;
        end
        if ((cmd_pol == POL_NONE) || (cmd_width == '0)) begin
            w_shaped = '0;
        end else if ({1'b0, cmd_width} < two_g) begin
            if (DROP_SHORT) begin
                w_shaped = '0;
            end else begin
                w_shaped = two_g;
            end
        end else begin
            w_shaped = {1'b0, cmd_width};
        end
        w_eff = (w_shaped > room) ? room : w_shaped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= TW'(WORD_TICKS);
            width_q <= '0;
            guard_w <= '0;
            pol_q   <= POL_NONE;
        end else if (word_go) begin
            tick_q  <= '0;
            width_q <= w_eff[TW-1:0];
            guard_w <= guard_nxt;
            pol_q   <= (w_eff != '0) ? cmd_pol : POL_NONE;
        end else if (tick_q != TW'(WORD_TICKS)) begin
            tick_q <= tick_q + 1'b1;
        end
    end

    // Pulse window: guard ticks after the word start, width ticks long
    always_comb begin
        end_t  = (TW+1)'(guard_w) + {1'b0, width_q};
        active = (width_q != '0)
                 && ({1'b0, tick_q} >= (TW+1)'(guard_w))
                 && ({1'b0, tick_q} < end_t);
    end

    assign drive_pos = active && (pol_q == POL_POS);
    assign drive_neg = active && (pol_q == POL_NEG);

endmodule

// File: rtl/gdt_leg_fsm.sv
module gdt_leg_fsm
    import gdt_pkg::*;
#(
    parameter int unsigned DEAD_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_high,
    output logic hi_en,
    output logic lo_en
);

    localparam int unsigned DW = $clog2(DEAD_TICKS + 1);

    leg_state_e    state_q;
    leg_state_e    state_nxt;
    logic [DW-1:0] dcnt_q;
    logic          dead_done;
    logic          raw_hi;
    logic          raw_lo;

    assign dead_done = (dcnt_q == DW'(DEAD_TICKS - 1));

    // State register with dead-time counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LEG_DEAD;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_nxt;
            if ((state_q == LEG_DEAD) && (state_nxt == LEG_DEAD)) begin
                dcnt_q <= dcnt_q + 1'b1;
            end else begin
                dcnt_q <= '0;
            end
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            LEG_LOW:  if (want_high)  state_nxt = LEG_DEAD;
            LEG_HIGH: if (!want_high) state_nxt = LEG_DEAD;
            LEG_DEAD: if (dead_done)  state_nxt = want_high ? LEG_HIGH : LEG_LOW;
            default:                  state_nxt = LEG_DEAD;
        endcase
    end

    // Outputs through the shoot-through interlock
    always_comb begin
        raw_hi = (state_q == LEG_HIGH);
        raw_lo = (state_q == LEG_LOW);
        hi_en  = raw_hi && !raw_lo;
        lo_en  = raw_lo && !raw_hi;
    end

endmodule

// File: rtl/hbridge_guard_deadtime.sv
module hbridge_guard_deadtime
    import gdt_pkg::*;
#(
    parameter int unsigned WORD_TICKS = 64,
    parameter int unsigned DEAD_TICKS = 2,
    parameter int unsigned GUARD_INIT = 3,
    parameter int unsigned GUARD_MIN  = 1,
    parameter int unsigned GUARD_MAX  = 6,
    parameter int unsigned AGREE_RUNS = 4,
    parameter bit          DROP_SHORT = 1'b0,
    localparam int unsigned TW        = $clog2(WORD_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_go,
    input  logic          cmd_pos,
    input  logic          cmd_neg,
    input  logic [TW-1:0] cmd_width,
    input  logic          isense_sign,
    output logic          a_hi_en,
    output logic          a_lo_en,
    output logic          b_hi_en,
    output logic          b_lo_en
);

    localparam int unsigned GW = $clog2(GUARD_MAX + 1);

    logic          sign_sync;
    logic [GW-1:0] guard_cur;
    logic [GW-1:0] guard_nxt;
    pol_e          last_pol;
    logic          drive_pos;
    logic          drive_neg;
    logic [LEGS-1:0] leg_drive;
    logic [LEGS-1:0] leg_hi;
    logic [LEGS-1:0] leg_lo;

    gdt_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (isense_sign),
        .q     (sign_sync)
    );

    gdt_guard_adapt #(
        .GW         (GW),
        .GUARD_INIT (GUARD_INIT),
        .GUARD_MIN  (GUARD_MIN),
        .GUARD_MAX  (GUARD_MAX),
        .AGREE_RUNS (AGREE_RUNS)
    ) u_adapt (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (word_go),
        .last_pol  (last_pol),
        .sign_now  (sign_sync),
        .guard_q   (guard_cur),
        .guard_nxt (guard_nxt)
    );

    gdt_word_timer #(
        .WORD_TICKS (WORD_TICKS),
        .GW         (GW),
        .TW         (TW),
        .DROP_SHORT (DROP_SHORT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_go   (word_go),
        .cmd_pos   (cmd_pos),
        .cmd_neg   (cmd_neg),
        .cmd_width (cmd_width),
        .guard_nxt (guard_nxt),
        .pol_q     (last_pol),
        .drive_pos (drive_pos),
        .drive_neg (drive_neg)
    );

    assign leg_drive[0] = drive_pos;
    assign leg_drive[1] = drive_neg;

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        gdt_leg_fsm #(.DEAD_TICKS(DEAD_TICKS)) u_leg (
            .clk       (clk),
            .rst_n     (rst_n),
            .want_high (leg_drive[g]),
            .hi_en     (leg_hi[g]),
            .lo_en     (leg_lo[g])
        );
    end

    assign a_hi_en = leg_hi[0];
    assign a_lo_en = leg_lo[0];
    assign b_hi_en = leg_hi[1];
    assign b_lo_en = leg_lo[1];

endmodule

// File: rtl/gdt_checker.sv
module gdt_checker #(
    parameter int unsigned DEAD_TICKS = 2,
    parameter int unsigned GUARD_MIN  = 1,
    parameter int unsigned GUARD_MAX  = 6,
    parameter int unsigned GW         = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          word_go,
    input logic          a_hi,
    input logic          a_lo,
    input logic          b_hi,
    input logic          b_lo,
    input logic [GW-1:0] guard
);

    localparam int unsigned CW = $clog2(DEAD_TICKS + 2);

    logic [CW-1:0] off_a;
    logic [CW-1:0] off_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_a <= '0;
            off_b <= '0;
        end else begin
            if (a_hi || a_lo)                    off_a <= '0;
            else if (off_a != CW'(DEAD_TICKS))  off_a <= off_a + 1'b1;
            if (b_hi || b_lo)                    off_b <= '0;
            else if (off_b != CW'(DEAD_TICKS))  off_b <= off_b + 1'b1;
        end
    end

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_off_chk: assert (!(a_hi || a_lo || b_hi || b_lo));
        end
    end

    // R2
    interlock_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hi && a_lo));

    // R2
    interlock_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_hi && b_lo));

    // R3
    dead_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_hi || a_lo) && (off_a != '0)) |-> (off_a >= CW'(DEAD_TICKS)));

    // R3
    dead_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((b_hi || b_lo) && (off_b != '0)) |-> (off_b >= CW'(DEAD_TICKS)));

    // R11
    high_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_hi && b_hi));

    // R7
    guard_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (guard >= GW'(GUARD_MIN)) && (guard <= GW'(GUARD_MAX)));

    // R10
    guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_go |=> $stable(guard));

    // R8
    guard_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_go |=> ((guard == $past(guard)) || (guard == $past(guard) + 1'b1)
                     || (guard == $past(guard) - 1'b1)));

endmodule

bind hbridge_guard_deadtime gdt_checker #(
    .DEAD_TICKS (DEAD_TICKS),
    .GUARD_MIN  (GUARD_MIN),
    .GUARD_MAX  (GUARD_MAX),
    .GW         (GW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_go (word_go),
    .a_hi    (a_hi_en),
    .a_lo    (a_lo_en),
    .b_hi    (b_hi_en),
    .b_lo    (b_lo_en),
    .guard   (guard_cur)
);

// File: tb/tb_hbridge_guard_deadtime.sv
module tb_hbridge_guard_deadtime;

    localparam int WORD  = 64;
    localparam int DEAD  = 2;
    localparam int GINIT = 3;
    localparam int GMIN  = 1;
    localparam int GMAX  = 6;
    localparam int AGREE = 4;
    localparam int NSAMP = WORD + 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       word_go = 1'b0;
    logic       go_drop = 1'b0;
    logic       cmd_pos = 1'b0;
    logic       cmd_neg = 1'b0;
    logic [6:0] cmd_width = '0;
    logic       isense = 1'b0;
    logic a_hi, a_lo, b_hi, b_lo;
    logic d_a_hi, d_a_lo, d_b_hi, d_b_lo;

    int checks = 0;
    int fails  = 0;
    int g_m = GINIT;
    int run_m = 0;
    int prev_m = 0;

    int fh_a, fh_b, fo_a, fo_b, nh_a, nh_b, both_hi, shoot, end_lo;

    always #4 clk = ~clk;

    hbridge_guard_deadtime dut (
        .clk(clk), .rst_n(rst_n), .word_go(word_go), .cmd_pos(cmd_pos),
        .cmd_neg(cmd_neg), .cmd_width(cmd_width), .isense_sign(isense),
        .a_hi_en(a_hi), .a_lo_en(a_lo), .b_hi_en(b_hi), .b_lo_en(b_lo));

    hbridge_guard_deadtime #(.DROP_SHORT(1'b1)) dut_drop (
        .clk(clk), .rst_n(rst_n), .word_go(go_drop), .cmd_pos(cmd_pos),
        .cmd_neg(cmd_neg), .cmd_width(cmd_width), .isense_sign(isense),
        .a_hi_en(d_a_hi), .a_lo_en(d_a_lo), .b_hi_en(d_b_hi), .b_lo_en(d_b_lo));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Guard model taken from R7, R8, R9; width shaping from R5, R6 (stretch mode)
    task automatic model(input bit pos, input bit neg, input int w, input bit sgn,
                         output int ew, output int epol);
        int pol;
        pol = (pos && !neg) ? 1 : ((neg && !pos) ? 2 : 0);
        if (prev_m != 0) begin
            bit exp_s;
            exp_s = (prev_m == 1);
            if (sgn != exp_s) begin
                run_m = 0;
                if (g_m < GMAX) g_m++;
            end else if (run_m == AGREE - 1) begin
                run_m = 0;
                if (g_m > GMIN) g_m--;
            end else begin
                run_m++;
            end
        end
        if (pol == 0 || w == 0) ew = 0;
        else if (w < 2 * g_m)   ew = 2 * g_m;
        else                    ew = w;
        if (ew > WORD - 2 * g_m) ew = WORD - 2 * g_m;
        epol   = (ew != 0) ? pol : 0;
        prev_m = epol;
    endtask

    task automatic launch(input bit pos, input bit neg, input int w, input bit sgn,
                          input bit drop);
        isense = sgn;
        repeat (3) @(negedge clk);
        cmd_pos = pos; cmd_neg = neg; cmd_width = 7'(w);
        if (drop) go_drop = 1'b1; else word_go = 1'b1;
        @(negedge clk);
        word_go = 1'b0; go_drop = 1'b0; cmd_pos = 1'b0; cmd_neg = 1'b0;
        fh_a = -1; fh_b = -1; fo_a = -1; fo_b = -1;
        nh_a = 0; nh_b = 0; both_hi = 0; shoot = 0; end_lo = 0;
        for (int i = 0; i < NSAMP; i++) begin
            logic ah, al, bh, bl;
            ah = drop ? d_a_hi : a_hi;  al = drop ? d_a_lo : a_lo;
            bh = drop ? d_b_hi : b_hi;  bl = drop ? d_b_lo : b_lo;
            if (ah) begin nh_a++; if (fh_a < 0) fh_a = i; end
            if (bh) begin nh_b++; if (fh_b < 0) fh_b = i; end
            if (!al && fo_a < 0) fo_a = i;
            if (!bl && fo_b < 0) fo_b = i;
            if (ah && bh) both_hi++;
            if ((ah && al) || (bh && bl)) shoot++;
            end_lo = (al && bl) ? 1 : 0;
            @(negedge clk);
        end
    endtask

    task automatic word(input string req, input bit pos, input bit neg, input int w,
                        input bit sgn);
        int ew, epol;
        model(pos, neg, w, sgn, ew, epol);
        launch(pos, neg, w, sgn, 1'b0);
        if (epol == 1) begin
            chk({req, " leg A high start"}, fh_a, g_m + 1 + DEAD);
            chk({req, " leg A high length"}, nh_a, ew - DEAD);
            chk("R3 leg A dead gap", fh_a - fo_a, DEAD);
            chk("R4 leg B idle", nh_b + (fo_b < 0 ? 0 : 1), 0);
        end else if (epol == 2) begin
            chk({req, " leg B high start"}, fh_b, g_m + 1 + DEAD);
            chk({req, " leg B high length"}, nh_b, ew - DEAD);
            chk("R3 leg B dead gap", fh_b - fo_b, DEAD);
            chk("R4 leg A idle", nh_a + (fo_a < 0 ? 0 : 1), 0);
        end else begin
            chk({req, " no pulse"}, nh_a + nh_b, 0);
            chk({req, " low sides held"}, (fo_a < 0 && fo_b < 0) ? 1 : 0, 1);
        end
        chk("R11 high sides exclusive", both_hi, 0);
        chk("R2 leg interlock", shoot, 0);
        chk("R3 low sides back on", end_lo, 1);
    endtask

    task automatic t_reset();
        int first;
        @(negedge clk);
        chk("R1 enables off in reset", {28'd0, a_hi, a_lo, b_hi, b_lo}, 0);
        chk("R1 drop copy off in reset", {28'd0, d_a_hi, d_a_lo, d_b_hi, d_b_lo}, 0);
        rst_n = 1'b1;
        first = -1;
        for (int k = 1; k <= DEAD + 3; k++) begin
            @(negedge clk);
            if (a_lo && b_lo && first < 0) first = k;
            chk("R1 high sides off after reset", {30'd0, a_hi, b_hi}, 0);
        end
        chk("R1 low sides on edge", first, DEAD);
    endtask

    task automatic t_basic();
        word("R4 positive", 1'b1, 1'b0, 20, 1'b1);
        word("R4 negative", 1'b0, 1'b1, 20, 1'b1);
        word("R4 both requests zero", 1'b1, 1'b1, 20, 1'b0);
    endtask

    task automatic t_raise();
        for (int n = 0; n < 5; n++) word("R7 mismatch raise", 1'b1, 1'b0, 20, 1'b0);
        word("R7 cap at max", 1'b1, 1'b0, 20, 1'b0);
        chk("R7 model at cap", g_m, GMAX);
    endtask

    task automatic t_skip();
        word("R8 match", 1'b1, 1'b0, 20, 1'b1);
        word("R9 zero width word", 1'b1, 1'b0, 0, 1'b1);
        word("R9 check skipped after idle word", 1'b1, 1'b0, 20, 1'b0);
        word("R8 run continues", 1'b1, 1'b0, 20, 1'b1);
    endtask

    task automatic t_lower();
        for (int n = 0; n < 24; n++) word("R8 match run lower", 1'b1, 1'b0, 20, 1'b1);
        chk("R8 floor reached", g_m, GMIN);
    endtask

    task automatic t_shape();
        word("R6 stretch short pulse", 1'b0, 1'b1, 1, 1'b0);
        word("R5 clamp wide pulse", 1'b0, 1'b1, 100, 1'b0);
        word("R6 stretch positive", 1'b1, 1'b0, 2, 1'b0);
    endtask

    // Guard raise and short-pulse stretch in the same word_go cycle
    task automatic t_same_cycle();
        word("R10 settle", 1'b1, 1'b0, 20, 1'b1);
        word("R10 raise and stretch together", 1'b1, 1'b0, 2 * g_m, 1'b0);
    endtask

    task automatic t_drop();
        launch(1'b1, 1'b0, 2, 1'b1, 1'b1);
        chk("R6 drop mode short pulse removed", nh_a + nh_b, 0);
        chk("R6 drop mode low sides held", (fo_a < 0 && fo_b < 0) ? 1 : 0, 1);
        launch(1'b1, 1'b0, 2 * GINIT, 1'b0, 1'b1);
        chk("R6 drop mode full pulse start", fh_a, GINIT + 1 + DEAD);
        chk("R6 drop mode full pulse length", nh_a, 2 * GINIT - DEAD);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_raise();
        t_skip();
        t_lower();
        t_shape();
        t_same_cycle();
        t_drop();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule